// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This block is the stack pointer of a small CPU whose stack starts at the top of a 16-bit address space and grows toward lower addresses. Out of reset the pointer holds 0xFFFF, which means the stack is empty. A push is post-decrement: the memory write uses the address the pointer holds now, and the pointer moves down by one afterwards. A pop is pre-increment: the pointer moves up by one first, and the memory read then uses the new address. A small sequencer runs both operations. It issues an address with a write or read strobe and updates the pointer, so a push takes one access cycle and a pop takes two cycles: one to increment, one to access.

Control logic can also load the pointer from a bus word. It can step the pointer up or down directly with a count enable, whose direction is set on a separate input. It can place the pointer on the address bus as a word, or place its high or low byte on the data bus.

The unit also drives memory-region selects. The top 16 KB of the address space is shared with a boot ROM, and the RAM there is selected only for stack accesses. Any other access to that window selects the ROM. The memory itself lies outside the block.

Top module: `stkptr_unit`

## Requirements
- R1: While reset is high and after it is released, the pointer reads 0xFFFF, the overflow flag is 0, and no memory strobe is active.
- R2: With load_n low at a rising edge, the pointer takes load_val. This has priority over a sequencer step and over a direct count in the same cycle, and it clears the overflow flag.
- R3: With cnt_en high at a rising edge and the sequencer idle, the pointer steps by one. The direction comes from cnt_down as sampled at the previous rising edge (1 = down, 0 = up), so a change of cnt_down in the same cycle as the count has no effect on that count.
- R4: Push, post-decrement. When push_req is sampled high while the sequencer is idle, the next cycle is the write cycle: mem_we = 1, addr_out = the old pointer and busy = 1. At the end of that cycle the pointer becomes old-1 and busy returns to 0.
- R5: Pop, pre-increment. When pop_req is sampled high while the sequencer is idle, the next cycle is the increment cycle: busy = 1, no strobe. The cycle after that is the read cycle: mem_re = 1 and addr_out = old+1. The pointer then stays at old+1.
- R6: If push_req and pop_req are both high while the sequencer is idle, the push is taken. Requests sampled while busy is high are ignored. mem_we and mem_re are never high together.
- R7: An increment from 0xFFFF wraps to 0x0000 and sets ovf_flag. The flag stays set until a load or a reset. A decrement from 0x0000 wraps to 0xFFFF and leaves the flag unchanged.
- R8: Outside a strobe cycle, word_oe_n low drives the pointer onto addr_out with addr_valid = 1. In a strobe cycle, addr_out carries the access address and addr_valid = 1. Otherwise addr_valid = 0.
- R9: hi_oe_n low puts bits 15:8 of the pointer on dout. If only lo_oe_n is low, dout carries bits 7:0. If both are low, the high byte wins. dout_valid is high when either enable is low.
- R10: When addr_valid is 1 and addr_out is at or above 0xC000, ram_sel is 1 only for a stack access (a strobe cycle, or stk_en_n low); otherwise rom_sel is 1 there. Below 0xC000, ram_sel = 1. With addr_valid = 0, both selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Load pointer from load_val, active low |
| load_val | input | 16 | Bus word for a load |
| cnt_en | input | 1 | Direct count enable |
| cnt_down | input | 1 | Count direction, 1 = down, applied one cycle later |
| push_req | input | 1 | Start a push sequence |
| pop_req | input | 1 | Start a pop sequence |
| word_oe_n | input | 1 | Drive pointer word to the address bus, active low |
| hi_oe_n | input | 1 | Drive high byte to the data bus, active low |
| lo_oe_n | input | 1 | Drive low byte to the data bus, active low |
| stk_en_n | input | 1 | External stack-access qualifier, active low |
| addr_out | output | 16 | Address bus word |
| addr_valid | output | 1 | addr_out is driven |
| dout | output | 8 | Data bus byte |
| dout_valid | output | 1 | dout is driven |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| busy | output | 1 | Sequencer is in a push or pop |
| ram_sel | output | 1 | RAM selected for the current address |
| rom_sel | output | 1 | ROM selected for the current address |
| ovf_flag | output | 1 | Sticky wrap flag on increment past 0xFFFF |

## Verification
The bench targets the ordering of each access against the pointer update. A design that decremented before a push would write one address too low. A design that read before the increment on a pop would return the old top. Both would show up in the strobe-cycle address. The wrap cases push from 0x0000 and pop from 0xFFFF. They catch a pointer that saturates, and an overflow flag that never sets or fires on the downward wrap. Further tests cover the one-cycle lag of the count direction, requests that arrive while busy, load priority, byte-lane selection, and the ROM window. A wrong window decode would select ROM for a stack write, or RAM for a plain fetch, near 0xC000.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

    localparam int unsigned SP_W      = 16;
    localparam int unsigned BYTE_W    = 8;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_PUSH_WR = 2'd1,
        SQ_POP_INC = 2'd2,
        SQ_POP_RD  = 2'd3
    } seq_state_e;

    // One pointer step request: enable plus direction (1 = down)
    typedef struct packed {
        logic step;
        logic down;
    } step_req_t;

    function automatic step_req_t pick_step(step_req_t seq_r, step_req_t cnt_r);
        return seq_r.step ? seq_r : cnt_r;
    endfunction

endpackage

// File: rtl/sp_core.sv
module sp_core
    import stkptr_pkg::*;
#(
    parameter int unsigned       W       = SP_W,
    parameter logic [W-1:0]      RST_VAL = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  step_req_t    req,
    output logic [W-1:0] sp,
    output logic         ovf
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            sp  <= RST_VAL;
            ovf <= 1'b0;
        end else if (load) begin
            sp  <= load_val;
            ovf <= 1'b0;
        end else if (req.step) begin
            if (req.down) begin
                sp <= sp - 1'b1;
            end else begin
                sp <= sp + 1'b1;
                if (sp == TOP) ovf <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sp_seq.sv
module sp_seq
    import stkptr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      push_req,
    input  logic      pop_req,
    output step_req_t seq_req,
    output logic      mem_we,
    output logic      mem_re,
    output logic      busy
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (push_req)     state_d = SQ_PUSH_WR;
                else if (pop_req) state_d = SQ_POP_INC;
            end
            SQ_PUSH_WR: state_d = SQ_IDLE;
            SQ_POP_INC: state_d = SQ_POP_RD;
            SQ_POP_RD:  state_d = SQ_IDLE;
            default:    state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    // Push: access then step down. Pop: step up then access.
    assign mem_we       = (state_q == SQ_PUSH_WR);
    assign mem_re       = (state_q == SQ_POP_RD);
    assign seq_req.step = (state_q == SQ_PUSH_WR) || (state_q == SQ_POP_INC);
    assign seq_req.down = (state_q == SQ_PUSH_WR);
    assign busy         = (state_q != SQ_IDLE);

endmodule

// File: rtl/sp_drive.sv
module sp_drive
    import stkptr_pkg::*;
#(
    parameter int unsigned  W        = SP_W,
    parameter logic [W-1:0] WIN_BASE = 16'hC000
) (
    input  logic              [W-1:0] sp,
    input  logic                      seq_access,
    input  logic                      word_oe_n,
    input  logic                      hi_oe_n,
    input  logic                      lo_oe_n,
    input  logic                      stk_en_n,
    output logic              [W-1:0] addr_out,
    output logic                      addr_valid,
    output logic         [BYTE_W-1:0] dout,
    output logic                      dout_valid,
    output logic                      ram_sel,
    output logic                      rom_sel
);

    localparam int unsigned NB = W / BYTE_W;

    logic [BYTE_W-1:0] lane [NB];

    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lane[g] = sp[g*BYTE_W +: BYTE_W];
    end

    assign addr_valid = seq_access | ~word_oe_n;
    assign addr_out   = addr_valid ? sp : '0;

    always_comb begin
        if (!hi_oe_n)      dout = lane[NB-1];
        else if (!lo_oe_n) dout = lane[0];
        else               dout = '0;
    end
    assign dout_valid = ~hi_oe_n | ~lo_oe_n;

    logic stack_acc, in_win;
    assign stack_acc = seq_access | ~stk_en_n;
    assign in_win    = (addr_out >= WIN_BASE);
    assign ram_sel   = addr_valid & (~in_win | stack_acc);
    assign rom_sel   = addr_valid & in_win & ~stack_acc;

endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
    import stkptr_pkg::*;
#(
    parameter int unsigned  W        = SP_W,
    parameter logic [W-1:0] WIN_BASE = 16'hC000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic [W-1:0]      load_val,
    input  logic              cnt_en,
    input  logic              cnt_down,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic              word_oe_n,
    input  logic              hi_oe_n,
    input  logic              lo_oe_n,
    input  logic              stk_en_n,
    output logic [W-1:0]      addr_out,
    output logic              addr_valid,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_valid,
    output logic              mem_we,
    output logic              mem_re,
    output logic              busy,
    output logic              ram_sel,
    output logic              rom_sel,
    output logic              ovf_flag
);

    logic      dir_q;
    step_req_t seq_req, cnt_req, core_req;
    logic [W-1:0] sp_q;

    // Direction is taken from the previous cycle
    always_ff @(posedge clk) begin
        if (rst) dir_q <= 1'b0;
        else     dir_q <= cnt_down;
    end

    assign cnt_req.step = cnt_en;
    assign cnt_req.down = dir_q;
    assign core_req     = pick_step(seq_req, cnt_req);

    sp_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_req),
        .pop_req  (pop_req),
        .seq_req  (seq_req),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .busy     (busy)
    );

    sp_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (~load_n),
        .load_val (load_val),
        .req      (core_req),
        .sp       (sp_q),
        .ovf      (ovf_flag)
    );

    sp_drive #(.W(W), .WIN_BASE(WIN_BASE)) u_drive (
        .sp         (sp_q),
        .seq_access (mem_we | mem_re),
        .word_oe_n  (word_oe_n),
        .hi_oe_n    (hi_oe_n),
        .lo_oe_n    (lo_oe_n),
        .stk_en_n   (stk_en_n),
        .addr_out   (addr_out),
        .addr_valid (addr_valid),
        .dout       (dout),
        .dout_valid (dout_valid),
        .ram_sel    (ram_sel),
        .rom_sel    (rom_sel)
    );

endmodule

// File: rtl/stkptr_chk.sv
module stkptr_chk #(
    parameter int unsigned  W        = 16,
    parameter logic [W-1:0] WIN_BASE = 16'hC000
) (
    input logic         clk,
    input logic         rst,
    input logic         load_n,
    input logic [W-1:0] load_val,
    input logic [W-1:0] sp_q,
    input logic         ovf,
    input logic         mem_we,
    input logic         mem_re,
    input logic [W-1:0] addr_out,
    input logic         addr_valid,
    input logic         ram_sel,
    input logic         rom_sel
);

    a_r2_load_takes_value: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> sp_q == $past(load_val));

    a_r4_push_then_dec: assert property (@(posedge clk) disable iff (rst)
        (mem_we && load_n) |=> sp_q == $past(sp_q) - 1'b1);

    a_r5_read_after_inc: assert property (@(posedge clk) disable iff (rst)
        (mem_re && $past(load_n)) |-> addr_out == $past(sp_q) + 1'b1);

    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && load_n) |=> ovf);

    a_r7_ovf_from_top: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(sp_q) == {W{1'b1}});

    a_r8_strobe_drives_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> addr_valid);

    a_r10_sel_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ram_sel && rom_sel));

    a_r10_low_is_ram: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_out < WIN_BASE) |-> ram_sel);

    a_r10_idle_no_sel: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |-> (!ram_sel && !rom_sel));

endmodule

bind stkptr_unit stkptr_chk #(.W(W), .WIN_BASE(WIN_BASE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_n     (load_n),
    .load_val   (load_val),
    .sp_q       (sp_q),
    .ovf        (ovf_flag),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .addr_out   (addr_out),
    .addr_valid (addr_valid),
    .ram_sel    (ram_sel),
    .rom_sel    (rom_sel)
);

// File: tb/stkptr_unit_tb.sv
module stkptr_unit_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        load_n, cnt_en, cnt_down, push_req, pop_req;
    logic        word_oe_n, hi_oe_n, lo_oe_n, stk_en_n;
    logic [15:0] load_val;
    logic [15:0] addr_out;
    logic        addr_valid, dout_valid, mem_we, mem_re, busy, ram_sel, rom_sel, ovf_flag;
    logic [7:0]  dout;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    stkptr_unit u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .load_val(load_val),
        .cnt_en(cnt_en), .cnt_down(cnt_down), .push_req(push_req), .pop_req(pop_req),
        .word_oe_n(word_oe_n), .hi_oe_n(hi_oe_n), .lo_oe_n(lo_oe_n), .stk_en_n(stk_en_n),
        .addr_out(addr_out), .addr_valid(addr_valid), .dout(dout), .dout_valid(dout_valid),
        .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .ram_sel(ram_sel),
        .rom_sel(rom_sel), .ovf_flag(ovf_flag)
    );

    // op: 0 push, 1 pop, 2 count up, 3 count down ; {start, op, expected}
    localparam logic [33:0] VEC [6] = '{
        {16'h1234, 2'd0, 16'h1233},
        {16'h0000, 2'd0, 16'hFFFF},
        {16'hFFFE, 2'd1, 16'hFFFF},
        {16'h00FF, 2'd2, 16'h0100},
        {16'h8000, 2'd3, 16'h7FFF},
        {16'hC000, 2'd1, 16'hC001}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_load(logic [15:0] v);
        load_val = v;
        load_n   = 1'b0;
        tick();
        load_n   = 1'b1;
    endtask

    task automatic do_push();
        push_req = 1'b1;
        tick();
        push_req = 1'b0;
        tick();
    endtask

    task automatic do_pop();
        pop_req = 1'b1;
        tick();
        pop_req = 1'b0;
        tick();
        tick();
    endtask

    task automatic do_count(logic down);
        cnt_down = down;
        tick();
        cnt_en = 1'b1;
        tick();
        cnt_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 20000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; load_n = 1'b1; load_val = '0; cnt_en = 1'b0; cnt_down = 1'b0;
        push_req = 1'b0; pop_req = 1'b0; word_oe_n = 1'b0; hi_oe_n = 1'b1;
        lo_oe_n = 1'b1; stk_en_n = 1'b1;
        tick(); tick();
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 pointer", 32'(addr_out), 32'hFFFF);
        chk("R1 ovf", 32'(ovf_flag), 0);
        chk("R1 strobes", 32'({mem_we, mem_re, busy}), 0);

        // Vector table walk (R3, R4, R5, R7 wrap down)
        foreach (VEC[i]) begin
            do_load(VEC[i][33:18]);
            case (VEC[i][17:16])
                2'd0: do_push();
                2'd1: do_pop();
                2'd2: do_count(1'b0);
                default: do_count(1'b1);
            endcase
            #1;
            chk("R4/R5/R3 vector result", 32'(addr_out), 32'(VEC[i][15:0]));
        end

        // R4 push timing and address
        do_load(16'h2000);
        push_req = 1'b1; tick(); push_req = 1'b0;
        chk("R4 write strobe", 32'({mem_we, mem_re, busy}), 32'b101);
        chk("R4 write address old", 32'(addr_out), 32'h2000);
        tick();
        chk("R4 decremented, idle", 32'({addr_out, busy}), {15'd0, 16'h1FFF, 1'b0});

        // R5 pop timing and address
        do_load(16'h3000);
        pop_req = 1'b1; tick(); pop_req = 1'b0;
        chk("R5 inc cycle no strobe", 32'({mem_we, mem_re, busy}), 32'b001);
        tick();
        chk("R5 read strobe", 32'(mem_re), 1);
        chk("R5 read address new", 32'(addr_out), 32'h3001);
        tick();
        chk("R5 pointer after pop", 32'({addr_out, busy}), {15'd0, 16'h3001, 1'b0});

        // R6 both requests: push wins; request while busy ignored
        do_load(16'h4000);
        push_req = 1'b1; pop_req = 1'b1; tick(); push_req = 1'b0;
        chk("R6 push wins", 32'({mem_we, mem_re}), 32'b10);
        tick(); pop_req = 1'b0;
        tick();
        chk("R6 pop while busy ignored", 32'({addr_out, busy, mem_re}), {14'd0, 16'h3FFF, 2'b00});

        // R7 pop from empty wraps and flags
        do_load(16'hFFFF);
        pop_req = 1'b1; tick(); pop_req = 1'b0;
        tick();
        chk("R7 wrap address", 32'(addr_out), 32'h0000);
        chk("R7 ovf set", 32'(ovf_flag), 1);
        tick(); tick();
        chk("R7 ovf sticky", 32'(ovf_flag), 1);
        do_load(16'h0000);
        #1;
        chk("R7 load clears ovf", 32'(ovf_flag), 0);
        do_push();
        chk("R7 down wrap no flag", 32'({addr_out, ovf_flag}), {15'd0, 16'hFFFF, 1'b0});

        // R3 direction lag: cnt_down changes with cnt_en -> previous (up) used
        do_load(16'h0500);
        cnt_down = 1'b0; tick();
        cnt_down = 1'b1; cnt_en = 1'b1; tick(); cnt_en = 1'b0;
        chk("R3 direction from prior cycle", 32'(addr_out), 32'h0501);

        // R2 load priority over count and over sequencer step
        cnt_en = 1'b1; load_val = 16'hBEEF; load_n = 1'b0; tick();
        cnt_en = 1'b0; load_n = 1'b1;
        chk("R2 load beats count", 32'(addr_out), 32'hBEEF);
        push_req = 1'b1; tick(); push_req = 1'b0;
        load_val = 16'h1111; load_n = 1'b0; tick(); load_n = 1'b1;
        chk("R2 load beats push step", 32'(addr_out), 32'h1111);

        // R8 address drive off
        word_oe_n = 1'b1; #1;
        chk("R8 no drive", 32'(addr_valid), 0);
        chk("R10 no select", 32'({ram_sel, rom_sel}), 0);
        word_oe_n = 1'b0;

        // R9 byte lanes
        do_load(16'hA55A);
        hi_oe_n = 1'b0; #1;
        chk("R9 high byte", 32'({dout_valid, dout}), 32'h1A5);
        hi_oe_n = 1'b1; lo_oe_n = 1'b0; #1;
        chk("R9 low byte", 32'({dout_valid, dout}), 32'h15A);
        hi_oe_n = 1'b0; #1;
        chk("R9 both -> high", 32'(dout), 32'hA5);
        hi_oe_n = 1'b1; lo_oe_n = 1'b1; #1;
        chk("R9 none", 32'(dout_valid), 0);

        // R10 region selects
        do_load(16'hC100);
        stk_en_n = 1'b1; #1;
        chk("R10 window non-stack -> ROM", 32'({ram_sel, rom_sel}), 32'b01);
        stk_en_n = 1'b0; #1;
        chk("R10 window stack -> RAM", 32'({ram_sel, rom_sel}), 32'b10);
        stk_en_n = 1'b1;
        push_req = 1'b1; tick(); push_req = 1'b0;
        chk("R10 push strobe -> RAM", 32'({mem_we, ram_sel, rom_sel}), 32'b110);
        tick();
        do_load(16'hBFFF); #1;
        chk("R10 below window -> RAM", 32'({ram_sel, rom_sel}), 32'b10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule